// File: doc/BRIEF.md
# Register-File Serial Slave with Change Notification

This block is the host-facing side of a sensing controller. It is a slave on a two-wire I2C bus at standard-mode rates, and it answers one fixed 7-bit address. Through this bus it gives the host access to a 256-entry byte address space. The host loads an internal pointer with the first byte of a write. Data bytes that follow go to consecutive locations. Reads continue from the pointer until the host refuses a byte. When a transfer ends, the pointer returns to the last address the host loaded, so the host can poll one location again and again without resending it.

The sensing core supplies the key-detection and input-port status as plain inputs, and the block shows them as two status bytes. A bank of sixteen writable setup bytes is kept here. One of those bytes is a key mask. It selects which detection bits, and whether the calibrating flag, may raise the active-low change line. Any change on the input port always raises that line. Two command locations produce single-cycle request pulses toward the core. A line monitor resets the bus engine when either wire sits low with no activity for too long. A strap sampled during reset can place the block in standalone mode, in which the bus side stays silent.

Bus pins are modelled as open-drain: `sda_pull` and `chg_pull` high mean "drive the wire low".

Top module: `rsl_top`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 0x12, by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the rest of that transfer is ignored.
- R2: In a write transfer, the first byte after the address loads the pointer. Each later byte is stored at the pointer, and the pointer then increments. Every byte is acknowledged.
- R3: In a read transfer, the slave sends the byte at the pointer, MSB first. After every master acknowledge it sends the byte at the next address. It stops driving after a master not-acknowledge.
- R4: On every STOP or START, the pointer returns to the value last loaded by a write transfer. A read with no pointer byte therefore starts at that location.
- R5: The pointer wraps from 255 to 0.
- R6: Addresses 14 to 29 are read/write setup bytes. Their reset value is 0x00, except address 24 (key mask), which resets to 0xBF. Address 0 reads a device ID (default 0x5A) and address 1 reads a revision (default 0x13). Writes to all other addresses are ignored. Unassigned addresses read 0x00.
- R7: Writing a nonzero byte to address 12 gives a one-cycle `cal_req`. Writing a nonzero byte to address 13 gives a one-cycle `reset_req`. Writing zero gives no pulse.
- R8: `chg_pull` rises one clock after a change in any bit of `in_port`. It also rises after a change in `det_keys[k]` when key-mask bit k is set (k = 0 to 5), or after a change in `calibrating` when key-mask bit 7 is set. Masked bits have no effect.
- R9: Reading address 4 or 5 releases `chg_pull`. That read also records the current status as the host's last view.
- R10: A read of any other address releases `chg_pull` only if the masked status now equals the host's last view. This covers status that changed and then returned to its old value.
- R11: If SCL or SDA is low while neither wire changes for STUCK_CYC clocks, the bus engine returns to idle, releases SDA and restores the pointer. It then accepts a fresh transfer.
- R12: SDA low with SCL high, sampled during reset, sets `standalone`. In standalone mode the slave never drives SDA, acknowledges nothing and disables the line monitor.
- R13: The slave changes `sda_pull` only while SCL is low.
- R14: Address 4 reads {calibrating, 0, det_keys[5:0]} and address 5 reads {0, in_port[6:0]}. These bytes are read-only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; the strap is sampled while it is low |
| scl_i | input | 1 | Level of the bus clock wire |
| sda_i | input | 1 | Level of the bus data wire |
| sda_pull | output | 1 | 1 = drive the data wire low |
| chg_pull | output | 1 | 1 = drive the change wire low (change pending) |
| det_keys | input | 6 | Key detection flags from the sensing core |
| calibrating | input | 1 | Calibration-in-progress flag from the core |
| in_port | input | 7 | Input-port levels from the port logic |
| cal_req | output | 1 | One-cycle calibration request |
| reset_req | output | 1 | One-cycle device-reset request |
| standalone | output | 1 | Strap result: bus side disabled |

## Verification
The bench builds the block with STUCK_CYC set to 200 and keeps every other parameter at its default. The short stuck window lets a stalled read be released inside a few hundred clocks, which puts the monitor's timeout and the recovery that follows within reach. With the default ID and revision bytes, the read-only and unassigned addresses can be checked against known values. The default key-mask reset makes it possible to show both masked and unmasked status changes on the change line.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WR, ST_RD} rsl_state_e;

  localparam int          BYTE_W       = 8;
  localparam int          CFG_BASE     = 14;
  localparam int          CFG_N        = 16;
  localparam int          KEYMASK_IDX  = 10;
  localparam logic [7:0]  KEYMASK_DFLT = 8'hBF;
  localparam logic [7:0]  A_ID         = 8'd0;
  localparam logic [7:0]  A_REV        = 8'd1;
  localparam logic [7:0]  A_DET        = 8'd4;
  localparam logic [7:0]  A_INP        = 8'd5;
  localparam logic [7:0]  A_CAL        = 8'd12;
  localparam logic [7:0]  A_RST        = 8'd13;
endpackage

// File: rtl/rsl_line_mon.sv
module rsl_line_mon #(
  parameter int STUCK_CYC = 700000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic mon_en,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev,
  output logic stuck_rst
);
  localparam int CW = $clog2(STUCK_CYC + 1);

  logic scl_m, scl_s, scl_d, sda_m, sda_d;
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_m, scl_s, scl_d} <= 3'b111;
      {sda_m, sda_s, sda_d} <= 3'b111;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_d <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s && !scl_d;
  assign scl_fall = !scl_s && scl_d;
  assign start_ev = scl_s && scl_d && sda_d && !sda_s;
  assign stop_ev  = scl_s && scl_d && !sda_d && sda_s;

  // quiet-low watchdog: restarts on any wire edge or when both wires are high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt  <= '0;
      stuck_rst <= 1'b0;
    end else begin
      stuck_rst <= 1'b0;
      if (!mon_en || (scl_s != scl_d) || (sda_s != sda_d) || (scl_s && sda_s)) begin
        idle_cnt <= '0;
      end else if (idle_cnt == CW'(STUCK_CYC - 1)) begin
        idle_cnt  <= '0;
        stuck_rst <= 1'b1;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsl_byte_fsm.sv
module rsl_byte_fsm
  import rsl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       stuck_rst,
  input  logic [7:0] rd_data,
  output logic [7:0] ptr,
  output logic       sda_pull,
  output logic       wr_stb,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       rd_stb,
  output logic [7:0] rd_addr
);
  rsl_state_e st;
  logic [3:0] cnt;
  logic [7:0] rx, tx, home;
  logic       rw, first, mnack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; rx <= '0; tx <= '0; home <= '0; ptr <= '0;
      rw <= 1'b0; first <= 1'b0; mnack <= 1'b0; sda_pull <= 1'b0;
      wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0; rd_stb <= 1'b0; rd_addr <= '0;
    end else begin
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      if (!en || stuck_rst) begin
        st <= ST_IDLE; cnt <= '0; sda_pull <= 1'b0; ptr <= home;
      end else if (start_ev) begin
        st <= ST_ADDR; cnt <= '0; sda_pull <= 1'b0; ptr <= home;
      end else if (stop_ev) begin
        st <= ST_IDLE; sda_pull <= 1'b0; ptr <= home;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          cnt <= cnt + 4'd1;
          if (cnt < 4'd8) begin
            if (st != ST_RD) rx <= {rx[6:0], sda_s};
          end else begin
            mnack <= sda_s;
            if (st == ST_RD && !sda_s) ptr <= ptr + 8'd1;
          end
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            case (st)
              ST_RD:   sda_pull <= 1'b0;
              ST_ADDR: begin
                if (rx[7:1] == DEV_ADDR) begin
                  sda_pull <= 1'b1;
                  rw       <= rx[0];
                end else begin
                  st <= ST_IDLE;
                end
              end
              default: begin
                sda_pull <= 1'b1;
                if (first) begin
                  ptr   <= rx;
                  home  <= rx;
                  first <= 1'b0;
                end else begin
                  wr_stb  <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= rx;
                  ptr     <= ptr + 8'd1;
                end
              end
            endcase
          end else if (cnt == 4'd9) begin
            cnt      <= '0;
            sda_pull <= 1'b0;
            if ((st == ST_ADDR && rw) || (st == ST_RD && !mnack)) begin
              st       <= ST_RD;
              tx       <= rd_data;
              sda_pull <= !rd_data[7];
              rd_stb   <= 1'b1;
              rd_addr  <= ptr;
            end else if (st == ST_ADDR) begin
              st    <= ST_WR;
              first <= 1'b1;
            end else if (st == ST_RD) begin
              st <= ST_IDLE;
            end
          end else if (st == ST_RD && cnt != 4'd0) begin
            tx       <= {tx[6:0], 1'b0};
            sda_pull <= !tx[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/rsl_reg_bank.sv
module rsl_reg_bank
  import rsl_pkg::*;
#(
  parameter logic [7:0] DEV_ID = 8'h5A,
  parameter logic [7:0] REV_ID = 8'h13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] ptr,
  input  logic [7:0] det_byte,
  input  logic [7:0] inp_byte,
  output logic [7:0] rd_data,
  output logic [7:0] key_mask,
  output logic       cal_req,
  output logic       reset_req
);
  localparam int IW = $clog2(CFG_N);
  localparam logic [7:0] LO = 8'(CFG_BASE);
  localparam logic [7:0] HI = 8'(CFG_BASE + CFG_N);

  logic [7:0] cfg [CFG_N];
  logic [7:0] woff, roff;

  assign woff = wr_addr - LO;
  assign roff = ptr - LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CFG_N; i++)
        cfg[i] <= (i == KEYMASK_IDX) ? KEYMASK_DFLT : 8'h00;
      cal_req   <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      cal_req   <= wr_stb && (wr_addr == A_CAL) && (wr_data != 8'h00);
      reset_req <= wr_stb && (wr_addr == A_RST) && (wr_data != 8'h00);
      if (wr_stb && wr_addr >= LO && wr_addr < HI)
        cfg[woff[IW-1:0]] <= wr_data;
    end
  end

  assign key_mask = cfg[KEYMASK_IDX];

  always_comb begin
    rd_data = 8'h00;
    if (ptr >= LO && ptr < HI) begin
      rd_data = cfg[roff[IW-1:0]];
    end else begin
      case (ptr)
        A_ID:    rd_data = DEV_ID;
        A_REV:   rd_data = REV_ID;
        A_DET:   rd_data = det_byte;
        A_INP:   rd_data = inp_byte;
        default: rd_data = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/rsl_chg_track.sv
module rsl_chg_track
  import rsl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] det_byte,
  input  logic [7:0] inp_byte,
  input  logic [7:0] key_mask,
  input  logic       rd_stb,
  input  logic [7:0] rd_addr,
  output logic       chg_pull
);
  logic [7:0] mask_eff, prev_det, prev_inp, seen_det, seen_inp;
  logic       moved, same_as_seen, status_rd;

  assign mask_eff     = key_mask & 8'hBF;
  assign moved        = (((det_byte ^ prev_det) & mask_eff) != 8'h00) || (inp_byte != prev_inp);
  assign same_as_seen = (((det_byte ^ seen_det) & mask_eff) == 8'h00) && (inp_byte == seen_inp);
  assign status_rd    = rd_stb && (rd_addr == A_DET || rd_addr == A_INP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_det <= '0; prev_inp <= '0; seen_det <= '0; seen_inp <= '0;
      chg_pull <= 1'b0;
    end else begin
      prev_det <= det_byte;
      prev_inp <= inp_byte;
      if (status_rd) begin
        seen_det <= det_byte;
        seen_inp <= inp_byte;
      end
      if (moved)
        chg_pull <= 1'b1;
      else if (status_rd || (rd_stb && same_as_seen))
        chg_pull <= 1'b0;
    end
  end
endmodule

// File: rtl/rsl_top.sv
module rsl_top
  import rsl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h12,
  parameter int         STUCK_CYC = 700000,
  parameter logic [7:0] DEV_ID    = 8'h5A,
  parameter logic [7:0] REV_ID    = 8'h13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  output logic       chg_pull,
  input  logic [5:0] det_keys,
  input  logic       calibrating,
  input  logic [6:0] in_port,
  output logic       cal_req,
  output logic       reset_req,
  output logic       standalone
);
  logic       sda_s, scl_rise, scl_fall, start_ev, stop_ev, stuck_rst;
  logic [7:0] ptr, wr_addr, wr_data, rd_addr, rd_data, key_mask, det_byte, inp_byte;
  logic       wr_stb, rd_stb;

  // strap capture: follows the pins while reset is held, then freezes
  always_ff @(posedge clk) begin
    if (!rst_n) standalone <= !sda_i && scl_i;
  end

  assign det_byte = {calibrating, 1'b0, det_keys};
  assign inp_byte = {1'b0, in_port};

  rsl_line_mon #(.STUCK_CYC(STUCK_CYC)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .mon_en(!standalone),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .stuck_rst(stuck_rst)
  );

  rsl_byte_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(!standalone), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .stuck_rst(stuck_rst), .rd_data(rd_data), .ptr(ptr), .sda_pull(sda_pull),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_addr(rd_addr)
  );

  rsl_reg_bank #(.DEV_ID(DEV_ID), .REV_ID(REV_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .ptr(ptr), .det_byte(det_byte), .inp_byte(inp_byte), .rd_data(rd_data),
    .key_mask(key_mask), .cal_req(cal_req), .reset_req(reset_req)
  );

  rsl_chg_track u_chg (
    .clk(clk), .rst_n(rst_n), .det_byte(det_byte), .inp_byte(inp_byte),
    .key_mask(key_mask), .rd_stb(rd_stb), .rd_addr(rd_addr), .chg_pull(chg_pull)
  );
endmodule

// File: rtl/rsl_chk.sv
module rsl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_pull,
  input logic       chg_pull,
  input logic [5:0] det_keys,
  input logic       calibrating,
  input logic [6:0] in_port,
  input logic       cal_req,
  input logic       reset_req,
  input logic       standalone
);
  // R13
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_pull));

  // R7
  cal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |=> !cal_req);

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R12
  solo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standalone |-> !sda_pull);

  // R12
  solo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(standalone));

  // R8
  chg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(chg_pull) && $past(rst_n, 2)) |->
      (($past(in_port) != $past(in_port, 2)) ||
       ($past(det_keys) != $past(det_keys, 2)) ||
       ($past(calibrating) != $past(calibrating, 2))));
endmodule

bind rsl_top rsl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull(sda_pull), .chg_pull(chg_pull),
  .det_keys(det_keys), .calibrating(calibrating), .in_port(in_port),
  .cal_req(cal_req), .reset_req(reset_req), .standalone(standalone)
);

// File: tb/rsl_top_test.sv
`timescale 1ns/1ps
module rsl_top_test;
  localparam int STUCK = 200;
  localparam int Q = 5;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [5:0] det_keys = '0;
  logic calibrating = 1'b0;
  logic [6:0] in_port = '0;
  logic sda_pull, chg_pull, cal_req, reset_req, standalone;
  logic sda_line;
  logic [7:0] rbuf [8];
  int total = 0, bad = 0, cycles = 0, cal_cnt = 0, rst_cnt = 0;
  bit ack;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  rsl_top #(.STUCK_CYC(STUCK)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_pull(sda_pull),
    .chg_pull(chg_pull), .det_keys(det_keys), .calibrating(calibrating), .in_port(in_port),
    .cal_req(cal_req), .reset_req(reset_req), .standalone(standalone)
  );

  always @(negedge clk) begin
    cycles++;
    if (cal_req) cal_cnt++;
    if (reset_req) rst_cnt++;
    if (cycles >= 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp<150000", cycles);
      wrap_up();
    end
  end

  task automatic wrap_up();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic hp(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i_start();
    m_sda = 1'b1; hp(Q); m_scl = 1'b1; hp(H); m_sda = 1'b0; hp(H); m_scl = 1'b0; hp(Q);
  endtask

  task automatic i_stop();
    m_sda = 1'b0; hp(Q); m_scl = 1'b1; hp(H); m_sda = 1'b1; hp(H);
  endtask

  task automatic tx_byte(input logic [7:0] b, output bit a);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hp(Q); m_scl = 1'b1; hp(H); m_scl = 1'b0; hp(Q);
    end
    m_sda = 1'b1; hp(Q); m_scl = 1'b1; hp(H/2);
    a = !sda_line;
    hp(H/2); m_scl = 1'b0; hp(Q);
  endtask

  task automatic rx_byte(input int idx, input bit nack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(Q); m_scl = 1'b1; hp(H/2);
      rbuf[idx][i] = sda_line;
      hp(H/2); m_scl = 1'b0;
    end
    m_sda = nack; hp(Q); m_scl = 1'b1; hp(H); m_scl = 1'b0; hp(Q); m_sda = 1'b1;
  endtask

  task automatic wr_one(input logic [7:0] p, input logic [7:0] d);
    bit a;
    i_start(); tx_byte(8'h24, a); tx_byte(p, a); tx_byte(d, a); i_stop();
  endtask

  task automatic rd_n(input logic [7:0] p, input int n, input bit setp);
    bit a;
    if (setp) begin
      i_start(); tx_byte(8'h24, a); tx_byte(p, a); i_stop();
    end
    i_start(); tx_byte(8'h25, a);
    for (int i = 0; i < n; i++) rx_byte(i, i == n - 1);
    i_stop();
  endtask

  // {address, write data, expected read-back}
  localparam logic [23:0] VEC [6] = '{
    {8'd14, 8'h55, 8'h55},
    {8'd29, 8'hA5, 8'hA5},
    {8'd30, 8'h77, 8'h00},
    {8'd0,  8'h99, 8'h5A},
    {8'd3,  8'hFF, 8'h00},
    {8'd23, 8'h3C, 8'h3C}
  };

  initial begin
    hp(5); rst_n = 1'b1; hp(5);
    // reset state (R6, R12, R8)
    chk("R12 reset standalone", standalone, 0);
    chk("R13 reset sda_pull", sda_pull, 0);
    chk("R8 reset chg", chg_pull, 0);
    rd_n(8'd24, 1, 1); chk("R6 keymask default", rbuf[0], 8'hBF);
    rd_n(8'd1, 1, 1);  chk("R6 revision", rbuf[0], 8'h13);

    // address match (R1)
    i_start(); tx_byte(8'h26, ack); i_stop(); chk("R1 wrong addr nack", ack, 0);
    i_start(); tx_byte(8'h24, ack); i_stop(); chk("R1 own addr ack", ack, 1);

    // vector table (R2, R6)
    for (int v = 0; v < 6; v++) begin
      wr_one(VEC[v][23:16], VEC[v][15:8]);
      rd_n(VEC[v][23:16], 1, 1);
      chk("R6 table", rbuf[0], VEC[v][7:0]);
    end

    // multibyte write and read (R2, R3)
    i_start(); tx_byte(8'h24, ack); tx_byte(8'd16, ack);
    tx_byte(8'h11, ack); tx_byte(8'h22, ack); tx_byte(8'h33, ack); tx_byte(8'h44, ack);
    chk("R2 data ack", ack, 1);
    i_stop();
    rd_n(8'd16, 4, 1);
    chk("R3 byte0", rbuf[0], 8'h11); chk("R3 byte1", rbuf[1], 8'h22);
    chk("R3 byte2", rbuf[2], 8'h33); chk("R2 byte3", rbuf[3], 8'h44);

    // pointer returns to last loaded address (R4)
    rd_n(8'd0, 2, 0);
    chk("R4 revert a", rbuf[0], 8'h11); chk("R4 revert b", rbuf[1], 8'h22);

    // wrap (R5)
    rd_n(8'd255, 2, 1);
    chk("R5 at 255", rbuf[0], 8'h00); chk("R5 wrapped to 0", rbuf[1], 8'h5A);

    // command pulses (R7)
    wr_one(8'd12, 8'h01); hp(3); chk("R7 cal pulse", cal_cnt, 1);
    wr_one(8'd12, 8'h00); hp(3); chk("R7 cal zero", cal_cnt, 1);
    wr_one(8'd13, 8'h05); hp(3); chk("R7 reset pulse", rst_cnt, 1);

    // status layout and change line (R14, R8, R9)
    det_keys = 6'h2A; calibrating = 1'b1; in_port = 7'h55; hp(3);
    chk("R8 chg on change", chg_pull, 1);
    rd_n(8'd4, 2, 1);
    chk("R14 det byte", rbuf[0], 8'hAA); chk("R14 inp byte", rbuf[1], 8'h55);
    chk("R9 chg cleared", chg_pull, 0);

    in_port = 7'h54; hp(3); chk("R8 input change", chg_pull, 1);
    rd_n(8'd0, 1, 1); chk("R10 no clear if different", chg_pull, 1);
    rd_n(8'd5, 1, 1); chk("R14 inp", rbuf[0], 8'h54); chk("R9 clear on 5", chg_pull, 0);

    // masked bits (R8)
    wr_one(8'd24, 8'h3E);
    det_keys = 6'h2B; hp(3); chk("R8 masked key", chg_pull, 0);
    calibrating = 1'b0; hp(3); chk("R8 masked cal", chg_pull, 0);
    det_keys = 6'h29; hp(3); chk("R8 enabled key", chg_pull, 1);
    rd_n(8'd4, 1, 1); chk("R14 det", rbuf[0], 8'h29); chk("R9 clear on 4", chg_pull, 0);

    // revert before read (R10)
    in_port = 7'h50; hp(3); in_port = 7'h54; hp(3);
    chk("R10 held after revert", chg_pull, 1);
    rd_n(8'd14, 1, 1); chk("R10 any read clears", chg_pull, 0);

    // stuck bus (R11)
    i_start(); tx_byte(8'h24, ack); tx_byte(8'd30, ack); i_stop();
    i_start(); tx_byte(8'h25, ack); hp(Q);
    chk("R11 slave driving", sda_pull, 1);
    hp(STUCK + 50);
    chk("R11 released", sda_pull, 0);
    m_scl = 1'b1; hp(H);
    rd_n(8'd14, 1, 1); chk("R11 recovered", rbuf[0], 8'h55);

    // standalone strap (R12)
    rst_n = 1'b0; m_sda = 1'b0; m_scl = 1'b1; hp(5); rst_n = 1'b1; hp(3);
    m_sda = 1'b1; hp(H);
    chk("R12 strap", standalone, 1);
    i_start(); tx_byte(8'h24, ack); i_stop(); chk("R12 no ack", ack, 0);

    rst_n = 1'b0; hp(5); rst_n = 1'b1; hp(5);
    chk("R12 normal", standalone, 0);
    rd_n(8'd14, 1, 1); chk("R6 reset default", rbuf[0], 8'h00);

    wrap_up();
  end
endmodule